// File: doc/BRIEF.md
# Gated Seconds Counter

This block keeps a 32-bit binary count of elapsed seconds. Its clock is the 32.768 kHz timebase itself. A divider of `DIV_W` bits, 15 by default, wraps once per second and issues a one-cycle tick, and that tick advances the count. A host bus block sees the count as four byte registers and one control byte, through a simple byte-wide write port and a byte-wide read port.

The control byte holds an active-high stop flag, bit 7. A supply-mode input says whether the part runs from main or backup power, and the stop flag acts differently in each mode:

- **Main supply:** the timebase keeps running and only the count is held.
- **Backup supply:** the divider freezes as well, as if the oscillator had been switched off.

Reading the least significant count byte takes a snapshot of all four bytes. Later reads of the upper bytes return that snapshot, so a multi-byte read is coherent even when a tick falls in the middle of it.

Top module: `sec_count_core`

## Requirements
- R1: With the count running, it advances by exactly one every 2^DIV_W clock cycles.
- R2: Byte addresses 0, 1, 2 and 3 hold count bits [7:0], [15:8], [23:16] and [31:24]. A write to one of these addresses changes only that byte.
- R3: Address 4 is the control byte, and bit 7 is the stop flag (1 = stop). A read of address 4 returns only bit 7, with bits 6..0 reading 0. Addresses 5 to 7 read 0.
- R4: With backup_i = 0 and the stop flag at 1, the count holds. The divider keeps running, so once the flag is cleared the next increment keeps its original phase.
- R5: With backup_i = 1 and the stop flag at 1, both the divider and the count hold.
- R6: With backup_i = 1 and the stop flag at 0, the count advances as in R1.
- R7: A write to any count byte clears the divider. The next increment lands on the 2^DIV_W-th clock edge after the write edge.
- R8: A read of address 0 copies all four count bytes into a snapshot. Reads of addresses 1 to 3 return snapshot bytes, not the live count.
- R9: The count wraps from FFFFFFFFh to 00000000h.
- R10: After reset, the count, the snapshot, the stop flag and rd_data_o are all 0.
- R11: rd_data_o takes its new value on the clock edge that samples rd_en_i high. It holds that value while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| backup_i | input | 1 | 1 = running from backup supply |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Byte read strobe |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | 8 | Read data, registered |

## Verification
An increment lands on the edge after the cycle in which the divider sits at its maximum. A write to a count byte therefore moves the next increment to exactly 2^DIV_W edges after the write edge. A read result is due on the edge that samples the strobe and shows the count as it stood before that edge. The bench runs the divider at 3 bits, drives on falling edges and schedules each read on a counted edge: one read lands on the edge of an expected increment and must return the old value, and the read on the next edge must return the new one. Placed this way, the reads pin down the exact increment edge, the effect of a stop window in each supply mode on the divider's phase, and the coherence of a snapshot taken one edge before a carry across all four bytes.

// File: rtl/sec_count_pkg.sv
package sec_count_pkg;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned STOP_BIT = 7;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
   parameter int unsigned DIV_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             clr_i,
   output logic [DIV_W-1:0] phase_o,
   output logic             tick_o
);
   localparam logic [DIV_W-1:0] PHASE_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      phase_o <= '0;
      else if (clr_i)  phase_o <= '0;
      else if (run_i)  phase_o <= phase_o + DIV_W'(1);
   end

   // a clear on the same edge wins over the wrap
   assign tick_o = run_i && !clr_i && (phase_o == PHASE_MAX);
endmodule

// File: rtl/sec_counter.sv
module sec_counter
   import sec_count_pkg::*;
#(
   parameter int unsigned NBYTES = 4,
   parameter int unsigned ADDR_W = 3,
   localparam int unsigned CNT_W = NBYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_sel_i,
   input  byte_t             wr_data_i,
   output logic [CNT_W-1:0]  value_o
);
   logic [CNT_W-1:0] next_val;

   assign next_val = inc_i ? value_o + CNT_W'(1) : value_o;

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      localparam logic [ADDR_W-1:0] LANE = ADDR_W'(b);
      byte_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            q <= '0;
         else if (wr_en_i && wr_sel_i == LANE)  q <= wr_data_i;
         else                                   q <= next_val[b*BYTE_W +: BYTE_W];
      end
      assign value_o[b*BYTE_W +: BYTE_W] = q;
   end
endmodule

// File: rtl/sec_read_port.sv
module sec_read_port
   import sec_count_pkg::*;
#(
   parameter int unsigned NBYTES      = 4,
   parameter int unsigned ADDR_W      = 3,
   parameter bit          SNAPSHOT_EN = 1'b1,
   localparam int unsigned CNT_W = NBYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic [CNT_W-1:0]  live_i,
   input  byte_t             ctrl_i,
   output logic [CNT_W-1:0]  snap_o,
   output byte_t             rd_data_o
);
   logic             take_snap;
   logic [CNT_W-1:0] view;
   byte_t            rd_next;

   assign take_snap = rd_en_i && (rd_addr_i == '0);

   if (SNAPSHOT_EN) begin : g_snap
      logic [CNT_W-1:0] shadow_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         shadow_q <= '0;
         else if (take_snap) shadow_q <= live_i;
      end
      assign snap_o = shadow_q;
      assign view   = shadow_q;
   end else begin : g_live
      assign snap_o = live_i;
      assign view   = live_i;
   end

   always_comb begin
      rd_next = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (rd_addr_i == ADDR_W'(i))
            rd_next = (i == 0) ? live_i[BYTE_W-1:0] : view[i*BYTE_W +: BYTE_W];
      end
      if (rd_addr_i == ADDR_W'(NBYTES)) rd_next = ctrl_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data_o <= '0;
      else if (rd_en_i) rd_data_o <= rd_next;
   end
endmodule

// File: rtl/sec_count_core.sv
module sec_count_core
   import sec_count_pkg::*;
#(
   parameter int unsigned DIV_W       = 15,
   parameter int unsigned NBYTES      = 4,
   parameter int unsigned ADDR_W      = 3,
   parameter bit          SNAPSHOT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              backup_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [7:0]        wr_data_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o
);
   localparam int unsigned CNT_W = NBYTES * BYTE_W;
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NBYTES);

   if (DIV_W < 2 || DIV_W > 31) begin : g_bad_div
      $error("DIV_W out of range");
   end
   if (NBYTES < 1 || NBYTES > 8) begin : g_bad_bytes
      $error("NBYTES out of range");
   end
   if (NBYTES + 1 > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for count bytes plus control");
   end

   logic             stop_q;
   logic             wr_cnt;
   logic             osc_run;
   logic             tick;
   logic             snap_take;
   logic [DIV_W-1:0] phase;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] snap_q;
   byte_t            ctrl_byte;
   logic             unused_ctrl_bits;

   assign wr_cnt    = wr_en_i && (wr_addr_i < CTRL_ADDR);
   assign osc_run   = !backup_i || !stop_q;
   assign snap_take = rd_en_i && (rd_addr_i == '0);
   assign unused_ctrl_bits = ^wr_data_i[STOP_BIT-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     stop_q <= 1'b0;
      else if (wr_en_i && wr_addr_i == CTRL_ADDR)     stop_q <= wr_data_i[STOP_BIT];
   end

   always_comb begin
      ctrl_byte           = '0;
      ctrl_byte[STOP_BIT] = stop_q;
   end

   sec_prescaler #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (osc_run),
      .clr_i   (wr_cnt),
      .phase_o (phase),
      .tick_o  (tick)
   );

   sec_counter #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (tick && !stop_q),
      .wr_en_i   (wr_cnt),
      .wr_sel_i  (wr_addr_i),
      .wr_data_i (wr_data_i),
      .value_o   (cnt_q)
   );

   sec_read_port #(.NBYTES(NBYTES), .ADDR_W(ADDR_W), .SNAPSHOT_EN(SNAPSHOT_EN)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en_i   (rd_en_i),
      .rd_addr_i (rd_addr_i),
      .live_i    (cnt_q),
      .ctrl_i    (ctrl_byte),
      .snap_o    (snap_q),
      .rd_data_o (rd_data_o)
   );
endmodule

// File: rtl/sec_count_chk.sv
module sec_count_chk #(
   parameter int unsigned DIV_W       = 15,
   parameter int unsigned NBYTES      = 4,
   parameter bit          SNAPSHOT_EN = 1'b1,
   localparam int unsigned CNT_W = NBYTES * 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             backup_i,
   input logic             stop_i,
   input logic             wr_cnt_i,
   input logic             snap_take_i,
   input logic [DIV_W-1:0] phase_i,
   input logic [CNT_W-1:0] cnt_i,
   input logic [CNT_W-1:0] snap_i
);
   localparam logic [DIV_W-1:0] PHASE_MAX = '1;

   // R1 R9
   step_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_cnt_i && !stop_i && phase_i == PHASE_MAX) |=> (cnt_i == $past(cnt_i) + CNT_W'(1)));

   // R1
   no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt_i |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + CNT_W'(1)));

   // R4
   hold_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!backup_i && stop_i && !wr_cnt_i) |=> $stable(cnt_i));

   // R5
   hold_backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (backup_i && stop_i && !wr_cnt_i) |=> ($stable(phase_i) && $stable(cnt_i)));

   // R7
   clear_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt_i |=> (phase_i == '0));

   // R8
   snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SNAPSHOT_EN && snap_take_i) |=> (snap_i == $past(cnt_i)));
endmodule

bind sec_count_core sec_count_chk #(
   .DIV_W(DIV_W), .NBYTES(NBYTES), .SNAPSHOT_EN(SNAPSHOT_EN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .backup_i    (backup_i),
   .stop_i      (stop_q),
   .wr_cnt_i    (wr_cnt),
   .snap_take_i (snap_take),
   .phase_i     (phase),
   .cnt_i       (cnt_q),
   .snap_i      (snap_q)
);

// File: tb/tb_sec_count_core.sv
module tb_sec_count_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       backup_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [2:0] wr_addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic       rd_en_i = 1'b0;
   logic [2:0] rd_addr_i = '0;
   logic [7:0] rd_data_o;

   int checks = 0;
   int errors = 0;
   logic [7:0] v;

   always #10 clk = ~clk;

   sec_count_core #(.DIV_W(3)) dut (
      .clk(clk), .rst_n(rst_n), .backup_i(backup_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(posedge clk); @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      rd_en_i = 1'b1; rd_addr_i = a;
      @(posedge clk); @(negedge clk);
      rd_en_i = 1'b0;
      d = rd_data_o;
   endtask

   task automatic t_reset;
      @(negedge clk); rst_n = 1'b1;
      chk("R10 rd_data", rd_data_o, 8'h00);
      for (int i = 0; i < 5; i++) begin
         rd(3'(i), v); chk("R10 reg", v, 8'h00);
      end
   endtask

   task automatic t_bytes;
      wr(3'd4, 8'h80);
      wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'h33); wr(3'd3, 8'h44);
      rd(3'd0, v); chk("R2 b0", v, 8'h11);
      rd(3'd1, v); chk("R2 b1", v, 8'h22);
      rd(3'd2, v); chk("R2 b2", v, 8'h33);
      rd(3'd3, v); chk("R2 b3", v, 8'h44);
      wr(3'd2, 8'hA5);
      rd(3'd0, v); chk("R2 keep b0", v, 8'h11);
      rd(3'd1, v); chk("R2 keep b1", v, 8'h22);
      rd(3'd2, v); chk("R2 new b2", v, 8'hA5);
      rd(3'd3, v); chk("R2 keep b3", v, 8'h44);
   endtask

   task automatic t_rate;
      wr(3'd4, 8'h00);
      wr(3'd0, 8'h10);
      repeat (7) @(negedge clk);
      rd(3'd0, v); chk("R7 before", v, 8'h10);
      rd(3'd0, v); chk("R7 after", v, 8'h11);
      repeat (6) @(negedge clk);
      rd(3'd0, v); chk("R1 before", v, 8'h11);
      rd(3'd0, v); chk("R1 after", v, 8'h12);
   endtask

   task automatic t_main_stop;
      wr(3'd0, 8'h20);
      wr(3'd4, 8'h80);
      repeat (2) @(negedge clk);
      wr(3'd4, 8'h00);
      repeat (3) @(negedge clk);
      rd(3'd0, v); chk("R4 phase kept before", v, 8'h20);
      rd(3'd0, v); chk("R4 phase kept after", v, 8'h21);
      wr(3'd4, 8'h80);
      repeat (40) @(negedge clk);
      rd(3'd0, v); chk("R4 held", v, 8'h21);
   endtask

   task automatic t_backup_stop;
      backup_i = 1'b1;
      repeat (20) @(negedge clk);
      rd(3'd0, v); chk("R5 held", v, 8'h21);
      wr(3'd4, 8'h00);
      wr(3'd0, 8'h30);
      wr(3'd4, 8'h80);
      repeat (2) @(negedge clk);
      wr(3'd4, 8'h00);
      repeat (6) @(negedge clk);
      rd(3'd0, v); chk("R5 delayed before", v, 8'h30);
      rd(3'd0, v); chk("R5 delayed after", v, 8'h31);
   endtask

   task automatic t_backup_run;
      wr(3'd0, 8'h40);
      repeat (7) @(negedge clk);
      rd(3'd0, v); chk("R6 before", v, 8'h40);
      rd(3'd0, v); chk("R6 after", v, 8'h41);
      backup_i = 1'b0;
   endtask

   task automatic t_snap;
      wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'h12);
      repeat (6) @(negedge clk);
      rd(3'd0, v); chk("R8 b0", v, 8'hFF);
      rd(3'd1, v); chk("R8 b1", v, 8'hFF);
      rd(3'd2, v); chk("R8 b2", v, 8'hFF);
      rd(3'd3, v); chk("R8 b3", v, 8'h12);
      rd(3'd0, v); chk("R8 fresh b0", v, 8'h00);
      rd(3'd3, v); chk("R8 fresh b3", v, 8'h13);
   endtask

   task automatic t_wrap;
      wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
      repeat (7) @(negedge clk);
      rd(3'd0, v); chk("R9 before", v, 8'hFF);
      rd(3'd0, v); chk("R9 b0", v, 8'h00);
      rd(3'd1, v); chk("R9 b1", v, 8'h00);
      rd(3'd2, v); chk("R9 b2", v, 8'h00);
      rd(3'd3, v); chk("R9 b3", v, 8'h00);
   endtask

   task automatic t_ctrl;
      wr(3'd4, 8'hFF);
      rd(3'd4, v); chk("R3 ctrl set", v, 8'h80);
      repeat (3) @(negedge clk);
      chk("R11 hold", rd_data_o, 8'h80);
      rd(3'd5, v); chk("R3 addr5", v, 8'h00);
      rd(3'd7, v); chk("R3 addr7", v, 8'h00);
      wr(3'd4, 8'h7F);
      rd(3'd4, v); chk("R3 ctrl clear", v, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      t_bytes;
      t_rate;
      t_main_stop;
      t_backup_stop;
      t_backup_run;
      t_snap;
      t_wrap;
      t_ctrl;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule